// File: doc/BRIEF.md
# Hashed Page Table Walker

This block turns a (virtual page number, process ID) pair into a physical page number by searching a hashed translation table that sits in main memory. A table base address picks where the table starts. Each table slot is a group of eight consecutive entry words. The walker hashes the request to a primary slot and reads that slot's entries one at a time through a single-outstanding memory read port. It stops at the first entry that matches.

If the primary slot holds no match, a second hash picks a fallback slot, and that slot is searched the same way. When both slots fail, the walker reports a miss. Software then resolves the translation from its own complete table. Only one walk runs at a time. A new request is taken only while the walker is idle.

Top module: `hpt_walker`

## Requirements
- R1: Entry word k (0 to 7) of slot s is read from address `base_addr + s*8 + k`. Within a slot, entries are read in the order k = 0, 1, ..., 7. With the default table of 16 slots, no address outside `base_addr` to `base_addr + 127` is ever read.
- R2: The primary slot index is the XOR of all 4-bit groups of the 16-bit VPN (bits 3:0, 7:4, 11:8, 15:12) and the 4-bit PID. The first read of every walk is entry 0 of this slot.
- R3: The secondary slot index is the bitwise complement of the primary index, masked to 4 bits. It is searched, entries 0 to 7, only after all eight primary entries have failed to match.
- R4: An entry word holds the PPN in bits 11:0, the VPN tag in bits 27:12, the PID in bits 31:28 and a valid flag in bit 32. The entry matches only when the flag is 1 and both tag and PID equal the request. The first matching entry ends the walk: `res_hit`=1, `res_ppn` is that entry's PPN, and no further read is issued for the walk.
- R5: When none of the 16 searched entries matches, the walk ends after exactly 16 reads with `res_valid`=1 and `res_hit`=0.
- R6: `res_valid` is high for exactly one cycle per walk. `req_ready` is high again in the cycle that follows.
- R7: `req_ready` is low from the cycle after a request is accepted until the walk has ended. A request presented during a walk is ignored and has no effect on the walk's reads or its result.
- R8: At most one memory read is outstanding: after a read request is accepted, no new one is made until its response arrives. While `mem_req_ready` is low, `mem_req_valid` stays high and `mem_req_addr` stays unchanged.
- R9: After reset, `req_ready`=1, `res_valid`=0 and `mem_req_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| base_addr | input | 20 | Table base address, in entry words |
| req_valid | input | 1 | Lookup request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_vpn | input | 16 | Requested virtual page number |
| req_pid | input | 4 | Requested process ID |
| mem_req_valid | output | 1 | Memory read request |
| mem_req_ready | input | 1 | Memory accepts the read request |
| mem_req_addr | output | 20 | Address of the entry word to read |
| mem_rsp_valid | input | 1 | Read data returned |
| mem_rsp_data | input | 33 | Entry word returned |
| res_valid | output | 1 | One-cycle result strobe |
| res_hit | output | 1 | Result is a hit (1) or a miss for software (0) |
| res_ppn | output | 12 | Translated physical page number on a hit |

## Verification
The properties check the port handshake rules on every cycle: one read outstanding at a time, a request held stable until it is accepted, no ready while busy, a one-cycle result strobe, and a hit result directly after a matching response. What they cannot show is the search order and the hash arithmetic. The bench's sweeps cover every PID, every match position in both slots, and the miss case. In each walk, the bench rebuilds the full address sequence and the first-match result from the hash formulas, with decoy entries placed ahead of the match: a wrong PID, a wrong tag, or an invalid flag.

// File: rtl/hpt_pkg.sv
package hpt_pkg;

  typedef enum logic [1:0] {
    WALK_IDLE  = 2'd0,
    WALK_ISSUE = 2'd1,
    WALK_WAIT  = 2'd2,
    WALK_DONE  = 2'd3
  } walk_state_t;

  typedef enum logic {
    SLOT_PRIMARY   = 1'b0,
    SLOT_SECONDARY = 1'b1
  } slot_sel_t;

endpackage

// File: rtl/hpt_hash.sv
module hpt_hash #(
  parameter int VPN_W = 16,
  parameter int PID_W = 4,
  parameter int IDX_W = 4
) (
  input  logic [VPN_W-1:0] vpn,
  input  logic [PID_W-1:0] pid,
  output logic [IDX_W-1:0] prim_idx,
  output logic [IDX_W-1:0] sec_idx
);

  // Fold every bit of vpn and pid onto IDX_W lanes with XOR.
  function automatic logic [IDX_W-1:0] fold_xor(input logic [VPN_W-1:0] v,
                                                input logic [PID_W-1:0] p);
    logic [IDX_W-1:0] h;
    h = '0;
    for (int i = 0; i < VPN_W; i++) h[i % IDX_W] ^= v[i];
    for (int j = 0; j < PID_W; j++) h[j % IDX_W] ^= p[j];
    return h;
  endfunction

  function automatic logic [IDX_W-1:0] alt_hash(input logic [IDX_W-1:0] h);
    logic [IDX_W-1:0] mask;
    mask = '1;
    return (~h) & mask;
  endfunction

  always_comb begin
    prim_idx = fold_xor(vpn, pid);
    sec_idx  = alt_hash(prim_idx);
  end

endmodule

// File: rtl/hpt_addr_gen.sv
module hpt_addr_gen #(
  parameter int ADDR_W = 20,
  parameter int IDX_W  = 4,
  parameter int ENT_W  = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IDX_W-1:0]  slot,
  input  logic [ENT_W-1:0]  ent,
  output logic [ADDR_W-1:0] addr
);

  localparam int PAD_W = ADDR_W - IDX_W - ENT_W;

  // Entry address: base + slot*entries_per_slot + entry index.
  function automatic logic [ADDR_W-1:0] slot_addr(input logic [ADDR_W-1:0] b,
                                                  input logic [IDX_W-1:0]  s,
                                                  input logic [ENT_W-1:0]  e);
    return b + {{PAD_W{1'b0}}, s, e};
  endfunction

  always_comb addr = slot_addr(base, slot, ent);

endmodule

// File: rtl/hpt_entry_cmp.sv
module hpt_entry_cmp #(
  parameter int VPN_W = 16,
  parameter int PID_W = 4,
  parameter int PPN_W = 12,
  localparam int ENTRY_W = 1 + PID_W + VPN_W + PPN_W
) (
  input  logic [ENTRY_W-1:0] entry,
  input  logic [VPN_W-1:0]   vpn,
  input  logic [PID_W-1:0]   pid,
  output logic               match,
  output logic [PPN_W-1:0]   ppn
);

  function automatic logic entry_hit(input logic [ENTRY_W-1:0] w,
                                     input logic [VPN_W-1:0]   v,
                                     input logic [PID_W-1:0]   p);
    logic             vld;
    logic [VPN_W-1:0] tag;
    logic [PID_W-1:0] own;
    vld = w[ENTRY_W-1];
    tag = w[PPN_W +: VPN_W];
    own = w[PPN_W+VPN_W +: PID_W];
    return vld && (tag == v) && (own == p);
  endfunction

  always_comb begin
    match = entry_hit(entry, vpn, pid);
    ppn   = entry[PPN_W-1:0];
  end

endmodule

// File: rtl/hpt_walker.sv
module hpt_walker #(
  parameter int VPN_W   = 16,
  parameter int PID_W   = 4,
  parameter int PPN_W   = 12,
  parameter int ADDR_W  = 20,
  parameter int IDX_W   = 4,
  parameter int ENTRIES = 8,
  localparam int ENT_W   = $clog2(ENTRIES),
  localparam int ENTRY_W = 1 + PID_W + VPN_W + PPN_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  base_addr,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic [VPN_W-1:0]   req_vpn,
  input  logic [PID_W-1:0]   req_pid,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic [ADDR_W-1:0]  mem_req_addr,
  input  logic               mem_rsp_valid,
  input  logic [ENTRY_W-1:0] mem_rsp_data,
  output logic               res_valid,
  output logic               res_hit,
  output logic [PPN_W-1:0]   res_ppn
);
  import hpt_pkg::*;

  localparam logic [ENT_W-1:0] LAST_ENT = ENT_W'(ENTRIES - 1);

  walk_state_t      state_q;
  slot_sel_t        sel_q;
  logic [ENT_W-1:0] ent_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PID_W-1:0] pid_q;
  logic             hit_q;
  logic [PPN_W-1:0] ppn_q;

  logic [IDX_W-1:0] prim_idx, sec_idx, cur_slot;
  logic             ent_match;
  logic [PPN_W-1:0] ent_ppn;

  // Named events for the checker.
  logic walk_busy;
  logic match_ev;
  logic accept_ev;
  logic last_ent;

  hpt_hash #(.VPN_W(VPN_W), .PID_W(PID_W), .IDX_W(IDX_W)) hash_i (
    .vpn(vpn_q), .pid(pid_q), .prim_idx(prim_idx), .sec_idx(sec_idx)
  );

  assign cur_slot = (sel_q == SLOT_PRIMARY) ? prim_idx : sec_idx;

  hpt_addr_gen #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .ENT_W(ENT_W)) addr_i (
    .base(base_addr), .slot(cur_slot), .ent(ent_q), .addr(mem_req_addr)
  );

  hpt_entry_cmp #(.VPN_W(VPN_W), .PID_W(PID_W), .PPN_W(PPN_W)) cmp_i (
    .entry(mem_rsp_data), .vpn(vpn_q), .pid(pid_q),
    .match(ent_match), .ppn(ent_ppn)
  );

  assign walk_busy     = (state_q != WALK_IDLE);
  assign req_ready     = (state_q == WALK_IDLE);
  assign accept_ev     = req_ready && req_valid;
  assign mem_req_valid = (state_q == WALK_ISSUE);
  assign match_ev      = (state_q == WALK_WAIT) && mem_rsp_valid && ent_match;
  assign last_ent      = (ent_q == LAST_ENT);
  assign res_valid     = (state_q == WALK_DONE);
  assign res_hit       = hit_q;
  assign res_ppn       = ppn_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= WALK_IDLE;
      sel_q   <= SLOT_PRIMARY;
      ent_q   <= '0;
      vpn_q   <= '0;
      pid_q   <= '0;
      hit_q   <= 1'b0;
      ppn_q   <= '0;
    end else begin
      unique case (state_q)
        WALK_IDLE: begin
          if (accept_ev) begin
            vpn_q   <= req_vpn;
            pid_q   <= req_pid;
            sel_q   <= SLOT_PRIMARY;
            ent_q   <= '0;
            hit_q   <= 1'b0;
            state_q <= WALK_ISSUE;
          end
        end
        WALK_ISSUE: begin
          if (mem_req_ready) state_q <= WALK_WAIT;
        end
        WALK_WAIT: begin
          if (mem_rsp_valid) begin
            if (ent_match) begin
              hit_q   <= 1'b1;
              ppn_q   <= ent_ppn;
              state_q <= WALK_DONE;
            end else if (!last_ent) begin
              ent_q   <= ent_q + 1'b1;
              state_q <= WALK_ISSUE;
            end else if (sel_q == SLOT_PRIMARY) begin
              sel_q   <= SLOT_SECONDARY;
              ent_q   <= '0;
              state_q <= WALK_ISSUE;
            end else begin
              hit_q   <= 1'b0;
              state_q <= WALK_DONE;
            end
          end
        end
        WALK_DONE: state_q <= WALK_IDLE;
        default:   state_q <= WALK_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hpt_walker_chk.sv
module hpt_walker_chk #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              mem_rsp_valid,
  input logic              res_valid,
  input logic              res_hit,
  input logic              walk_busy,
  input logic              match_ev,
  input logic              accept_ev
);

  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n) outstanding <= 1'b0;
    else if (mem_req_valid && mem_req_ready) outstanding <= 1'b1;
    else if (mem_rsp_valid) outstanding <= 1'b0;
  end

  // R7
  busy_no_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> !req_ready);

  // R7
  walk_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid || (walk_busy && !res_valid)) |-> !req_ready);

  // R8
  single_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req_valid |-> !outstanding);

  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

  // R6
  res_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |=> (!res_valid && req_ready));

  // R4
  hit_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    match_ev |=> (res_valid && res_hit && !mem_req_valid));

endmodule

bind hpt_walker hpt_walker_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
  .res_valid(res_valid), .res_hit(res_hit), .walk_busy(walk_busy),
  .match_ev(match_ev), .accept_ev(accept_ev)
);

// File: tb/hpt_walker_tb_top.sv
`timescale 1ns/1ps
module hpt_walker_tb_top;

  localparam int VPN_W = 16, PID_W = 4, PPN_W = 12, ADDR_W = 20;
  localparam int ENTRY_W = 33;
  localparam int TBL_N = 128;
  localparam logic [ADDR_W-1:0] BASE = 20'h0_4A00;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic               rst_n;
  logic               req_valid = 1'b0;
  logic               req_ready;
  logic [VPN_W-1:0]   req_vpn = '0;
  logic [PID_W-1:0]   req_pid = '0;
  logic               mem_req_valid;
  logic               mem_req_ready = 1'b0;
  logic [ADDR_W-1:0]  mem_req_addr;
  logic               mem_rsp_valid = 1'b0;
  logic [ENTRY_W-1:0] mem_rsp_data = '0;
  logic               res_valid, res_hit;
  logic [PPN_W-1:0]   res_ppn;

  hpt_walker dut_i (
    .clk(clk), .rst_n(rst_n), .base_addr(BASE),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_vpn(req_vpn), .req_pid(req_pid),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .res_valid(res_valid),
    .res_hit(res_hit), .res_ppn(res_ppn)
  );

  int errors = 0;
  int checks = 0;

  logic [ENTRY_W-1:0] tbl [TBL_N];
  logic [ADDR_W-1:0]  addr_log [20];
  int nreads = 0;
  int bad_addr = 0;
  int cyc = 0;
  int dly = 0;
  bit pend = 0;
  bit slow = 0;
  logic [ADDR_W-1:0] paddr;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Memory model: decisions made at the falling edge.
  always @(negedge clk) begin
    cyc++;
    mem_rsp_valid = 1'b0;
    if (pend) begin
      if (dly == 0) begin
        if (paddr >= BASE && paddr < BASE + TBL_N) mem_rsp_data = tbl[int'(paddr - BASE)];
        else begin mem_rsp_data = '0; bad_addr++; end
        mem_rsp_valid = 1'b1;
        pend = 0;
      end else dly--;
    end else begin
      mem_req_ready = slow ? (cyc % 3 == 1) : 1'b1;
      if (mem_req_valid && mem_req_ready) begin
        paddr = mem_req_addr;
        if (nreads < 20) addr_log[nreads] = mem_req_addr;
        nreads++;
        pend = 1;
        dly = slow ? (cyc % 3) : 0;
      end
    end
  end

  function automatic logic [3:0] bhash(input logic [15:0] v, input logic [3:0] p);
    return v[3:0] ^ v[7:4] ^ v[11:8] ^ v[15:12] ^ p;
  endfunction

  task automatic walk(input logic [15:0] vpn, input logic [3:0] pid,
                      input int pos, input bit garb);
    logic [3:0] prim, sec, slot;
    logic [11:0] exp_ppn;
    int exp_reads, waited;
    string tag;
    prim = bhash(vpn, pid);
    sec = ~prim;
    exp_ppn = 12'(vpn * 3 + pid + pos);
    for (int i = 0; i < TBL_N; i++) tbl[i] = '0;
    for (int i = 0; i < 16; i++) begin
      int idx;
      slot = (i < 8) ? prim : sec;
      idx = int'(slot) * 8 + (i % 8);
      if (i < pos) begin
        case (i % 3)
          0: tbl[idx] = {1'b1, pid ^ 4'h1, vpn, exp_ppn ^ 12'h111};
          1: tbl[idx] = {1'b1, pid, vpn ^ 16'h0100, exp_ppn ^ 12'h222};
          default: tbl[idx] = {1'b0, pid, vpn, exp_ppn ^ 12'h333};
        endcase
      end else if (i == pos) tbl[idx] = {1'b1, pid, vpn, exp_ppn};
      else tbl[idx] = {1'b1, pid, vpn, exp_ppn ^ 12'hFFF};
    end
    exp_reads = (pos < 16) ? pos + 1 : 16;
    tag = garb ? "R7" : ((pos < 16) ? "R4" : "R5");

    @(negedge clk);
    check(req_ready == 1'b1, "R6", "ready before walk", req_ready, 1);
    nreads = 0; bad_addr = 0;
    req_vpn = vpn; req_pid = pid; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    waited = 0;
    while (!res_valid && waited < 2000) begin
      if (garb && nreads == 0) begin
        req_valid = 1'b1; req_vpn = ~vpn; req_pid = ~pid;
      end else req_valid = 1'b0;
      @(negedge clk);
      waited++;
    end
    req_valid = 1'b0;
    check(res_valid == 1'b1, tag, "result strobe", res_valid, 1);
    check(res_hit == (pos < 16), tag, "hit flag", res_hit, (pos < 16));
    if (pos < 16) check(res_ppn == exp_ppn, "R4", "ppn", res_ppn, exp_ppn);
    check(nreads == exp_reads, tag, "read count", nreads, exp_reads);
    check(bad_addr == 0, "R1", "out of table reads", bad_addr, 0);
    for (int i = 0; i < exp_reads && i < nreads; i++) begin
      logic [ADDR_W-1:0] ea;
      ea = BASE + ADDR_W'(((i < 8) ? int'(prim) : int'(sec)) * 8 + (i % 8));
      check(addr_log[i] == ea, (i == 0) ? "R2" : ((i < 8) ? "R1" : "R3"),
            "read address", addr_log[i], ea);
    end
    @(negedge clk);
    check(res_valid == 1'b0, "R6", "strobe one cycle", res_valid, 0);
    check(req_ready == 1'b1, "R6", "ready after result", req_ready, 1);
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready == 1'b1, "R9", "reset ready", req_ready, 1);
    check(res_valid == 1'b0, "R9", "reset result", res_valid, 0);
    check(mem_req_valid == 1'b0, "R9", "reset mem req", mem_req_valid, 0);
    for (int p = 0; p < 16; p++) begin
      for (int pos = 0; pos <= 16; pos++) begin
        logic [15:0] v;
        v = 16'(p * 16'h1111) ^ 16'(pos * 16'h0357 + 16'h00A5);
        slow = p[0];
        walk(v, 4'(p), pos, p[1]);
      end
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule